// File: doc/BRIEF.md
# Multicycle RISC Control Unit with Next-Instruction Prefetch

This block is the sequencing controller of a ten-state multicycle processor (states numbered 0 to 9). It is packaged with a small behavioural datapath: PC, instruction and data registers, a register file, one unified word memory and an add/subtract/logic ALU. The combination can run short programs and show the effect of the controller at its pins.

The controller differs from the classic sequence in one way. Load-word, R-type and jump do not spend a separate clock in the fetch state when they finish. Their last state also raises every fetch control: memory read at the PC, instruction-register load, and PC write of the fetch address plus 4. The next state is then decode. A load or an R-type instruction saves one clock this way.

Jump needs one extra path to do the same. A jump-prefetch select steers the computed jump target, in place of the PC, onto the fetch address. That address feeds both the memory and the ALU, so the instruction at the target is loaded and the PC becomes target + 4 in the same clock.

Store-word and branch-equal keep their classic ending and return to the fetch state. The parameter `PREFETCH_EN` = 0 builds the classic controller for comparison.

Top module: `mcpu_pf_core`

## Requirements
- R1: While rst_n is low, the state output is 0. PC is 0, and memory read/write, IR load, PC write, register write and the jump-prefetch select are all 0.
- R2: State 0 asserts memory read, IR load and PC write with the PC as the memory address. The next state is 1 and the PC advances by 4. The first instruction is fetched from address 0.
- R3: Load-word (opcode 100011) writes the memory word at rs + sign-extended offset into rt. With prefetch enabled, its final state 4 also performs the fetch and is followed by state 1.
- R4: R-type (opcode 000000) writes rd with add (funct 100000), sub (100010), and (100100), or (100101) or set-less-than (101010) of rs and rt. With prefetch enabled, its final state 7 also fetches and is followed by state 1.
- R5: Jump (opcode 000010) with prefetch enabled raises the jump-prefetch select in state 9 and in no other state. In that state it fetches from {PC[31:28], target, 00} and leaves the PC at that address + 4. The next state is 1. Instructions between the jump and its target never execute.
- R6: Store-word (opcode 101011) final state 5 and branch-equal (opcode 000100) final state 8 never prefetch and are followed by state 0. A store writes rt to memory. A taken branch goes to PC+4 + 4·offset, and a not-taken branch continues in sequence.
- R7: With prefetch enabled, the clocks from one decode to the next are: load 4, R-type 3, jump 2, store 4, branch 3, unknown opcode 2.
- R8: An opcode outside the five supported ones goes from state 1 back to state 0. It writes no register and no memory.
- R9: With PREFETCH_EN = 0, states 4, 7 and 9 are followed by state 0. In that build load takes 5 clocks, R-type 4 and jump 3, and the architectural results are the same as with prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Memory preload write strobe |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Register file observation index |
| dbg_reg_val | output | 32 | Selected register value |
| dbg_mem_sel | input | MEM_AW | Memory observation word index |
| dbg_mem_val | output | 32 | Selected memory word |
| pc_out | output | 32 | Program counter |
| state_out | output | 4 | Controller state number 0..9 |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write when ALU result is zero |
| pc_source | output | 2 | PC source: 0 ALU, 1 ALU register, 2 jump target |
| alu_src_a | output | 1 | ALU A: 0 fetch address, 1 register A |
| alu_src_b | output | 2 | ALU B: 0 register B, 1 constant 4, 2 immediate, 3 immediate·4 |
| alu_op | output | 2 | ALU op: 0 add, 1 subtract, 2 by funct |
| reg_write | output | 1 | Register file write |
| mem_to_reg | output | 1 | Write-back from memory data register |
| reg_dst | output | 1 | Destination: 1 rd, 0 rt |
| i_or_d | output | 1 | Memory address from ALU register (data) |
| pf_jump_sel | output | 1 | Fetch address taken from jump target |

## Verification
The bench builds two copies side by side with MEM_WORDS = 64: `dut_i` with PREFETCH_EN = 1 and a second copy with PREFETCH_EN = 0. Both run one program that mixes both loads, all five R-type functions, a forward jump over dead code, a store, a not-taken and a taken branch, an unknown opcode and a jump-to-self. The bench records every entry into decode, which gives the executed address sequence and the per-instruction clock count for each build. It compares these with lengths it derives from the opcode at each address. The register and memory results of both builds are checked against arithmetic done in the bench.

// File: rtl/mcpu_pf_pkg.sv
package mcpu_pf_pkg;

   localparam int XLEN   = 32;
   localparam int NREGS  = 32;
   localparam int RIDX_W = $clog2(NREGS);

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_LDMEM  = 4'd3,
      ST_LDWB   = 4'd4,
      ST_STMEM  = 4'd5,
      ST_EXEC   = 4'd6,
      ST_RWB    = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9
   } state_e;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;

   localparam logic [1:0] PCS_ALU  = 2'd0;
   localparam logic [1:0] PCS_AOUT = 2'd1;
   localparam logic [1:0] PCS_JMP  = 2'd2;

   localparam logic [1:0] SRCB_REG  = 2'd0;
   localparam logic [1:0] SRCB_FOUR = 2'd1;
   localparam logic [1:0] SRCB_IMM  = 2'd2;
   localparam logic [1:0] SRCB_IMM4 = 2'd3;

   localparam logic [1:0] AOP_ADD   = 2'd0;
   localparam logic [1:0] AOP_SUB   = 2'd1;
   localparam logic [1:0] AOP_FUNCT = 2'd2;

   typedef struct packed {
      logic       mem_read;
      logic       mem_write;
      logic       ir_write;
      logic       pc_write;
      logic       pc_write_cond;
      logic [1:0] pc_src;
      logic       alu_src_a;
      logic [1:0] alu_src_b;
      logic [1:0] alu_op;
      logic       reg_write;
      logic       mem_to_reg;
      logic       reg_dst;
      logic       i_or_d;
      logic       pf_jump_sel;
   } ctrl_t;

endpackage

// File: rtl/mcpu_pf_ctrl.sv
module mcpu_pf_ctrl
   import mcpu_pf_pkg::*;
#(
   parameter bit PREFETCH_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   output state_e     state_o,
   output ctrl_t      ctrl_o
);

   state_e state_q, state_d;
   ctrl_t  c;
   logic   tail_fetch;

   generate
      if (PREFETCH_EN) begin : g_tail_pf
         assign tail_fetch = 1'b1;
      end else begin : g_tail_classic
         assign tail_fetch = 1'b0;
      end
   endgenerate

   function automatic ctrl_t fetch_ctrl();
      ctrl_t f;
      f           = '0;
      f.mem_read  = 1'b1;
      f.ir_write  = 1'b1;
      f.pc_write  = 1'b1;
      f.pc_src    = PCS_ALU;
      f.alu_src_a = 1'b0;
      f.alu_src_b = SRCB_FOUR;
      f.alu_op    = AOP_ADD;
      f.i_or_d    = 1'b0;
      return f;
   endfunction

   always_comb begin
      c       = '0;
      state_d = ST_FETCH;
      unique case (state_q)
         ST_FETCH: begin
            c       = fetch_ctrl();
            state_d = ST_DECODE;
         end
         ST_DECODE: begin
            c.alu_src_a = 1'b0;
            c.alu_src_b = SRCB_IMM4;
            c.alu_op    = AOP_ADD;
            unique case (opcode)
               OPC_LOAD, OPC_STORE: state_d = ST_ADDR;
               OPC_RTYPE:           state_d = ST_EXEC;
               OPC_BEQ:             state_d = ST_BRANCH;
               OPC_JUMP:            state_d = ST_JUMP;
               default:             state_d = ST_FETCH;
            endcase
         end
         ST_ADDR: begin
            c.alu_src_a = 1'b1;
            c.alu_src_b = SRCB_IMM;
            c.alu_op    = AOP_ADD;
            state_d     = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
         end
         ST_LDMEM: begin
            c.mem_read = 1'b1;
            c.i_or_d   = 1'b1;
            state_d    = ST_LDWB;
         end
         ST_LDWB: begin
            if (tail_fetch) c = fetch_ctrl();
            c.reg_write  = 1'b1;
            c.mem_to_reg = 1'b1;
            c.reg_dst    = 1'b0;
            state_d      = tail_fetch ? ST_DECODE : ST_FETCH;
         end
         ST_STMEM: begin
            c.mem_write = 1'b1;
            c.i_or_d    = 1'b1;
            state_d     = ST_FETCH;
         end
         ST_EXEC: begin
            c.alu_src_a = 1'b1;
            c.alu_src_b = SRCB_REG;
            c.alu_op    = AOP_FUNCT;
            state_d     = ST_RWB;
         end
         ST_RWB: begin
            if (tail_fetch) c = fetch_ctrl();
            c.reg_write  = 1'b1;
            c.mem_to_reg = 1'b0;
            c.reg_dst    = 1'b1;
            state_d      = tail_fetch ? ST_DECODE : ST_FETCH;
         end
         ST_BRANCH: begin
            c.alu_src_a     = 1'b1;
            c.alu_src_b     = SRCB_REG;
            c.alu_op        = AOP_SUB;
            c.pc_write_cond = 1'b1;
            c.pc_src        = PCS_AOUT;
            state_d         = ST_FETCH;
         end
         ST_JUMP: begin
            if (tail_fetch) begin
               c             = fetch_ctrl();
               c.pf_jump_sel = 1'b1;
               state_d       = ST_DECODE;
            end else begin
               c.pc_write = 1'b1;
               c.pc_src   = PCS_JMP;
               state_d    = ST_FETCH;
            end
         end
         default: begin
            c       = '0;
            state_d = ST_FETCH;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_FETCH;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
   assign ctrl_o  = rst_n ? c : '0;

endmodule

// File: rtl/mcpu_pf_alu.sv
module mcpu_pf_alu
   import mcpu_pf_pkg::*;
(
   input  logic [1:0]      alu_op,
   input  logic [5:0]      funct,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] res,
   output logic            zero
);

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   logic [XLEN-1:0] diff;
   assign diff = opa - opb;

   always_comb begin
      res = opa + opb;
      if (alu_op == AOP_SUB) begin
         res = diff;
      end else if (alu_op == AOP_FUNCT) begin
         unique case (funct)
            FN_SUB:  res = diff;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_SLT:  res = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
            FN_ADD:  res = opa + opb;
            default: res = opa + opb;
         endcase
      end
   end

   assign zero = (res == '0);

endmodule

// File: rtl/mcpu_pf_dpath.sv
module mcpu_pf_dpath
   import mcpu_pf_pkg::*;
#(
   parameter  int MEM_WORDS = 64,
   localparam int AW        = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctrl,
   input  logic              load_we,
   input  logic [AW-1:0]     load_addr,
   input  logic [XLEN-1:0]   load_data,
   input  logic [RIDX_W-1:0] dbg_reg_sel,
   output logic [XLEN-1:0]   dbg_reg_val,
   input  logic [AW-1:0]     dbg_mem_sel,
   output logic [XLEN-1:0]   dbg_mem_val,
   output logic [XLEN-1:0]   pc_o,
   output logic [XLEN-1:0]   ir_o
);

   logic [XLEN-1:0] mem_q [MEM_WORDS];
   logic [XLEN-1:0] rf_q  [NREGS];

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aout_q;
   logic [XLEN-1:0] jump_tgt, fetch_addr, mem_addr, mem_rdata;
   logic [XLEN-1:0] imm_ext, alu_a, alu_b, alu_res, pc_next, wr_data;
   logic [AW-1:0]   word_idx;
   logic [RIDX_W-1:0] wr_idx;
   logic            alu_zero, pc_en;

   // Jump target built from the upper PC bits and the 26-bit field.
   assign jump_tgt   = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
   // Prefetch mux: the jump target stands in for the PC on the fetch path.
   assign fetch_addr = ctrl.pf_jump_sel ? jump_tgt : pc_q;
   assign mem_addr   = ctrl.i_or_d ? aout_q : fetch_addr;
   assign word_idx   = mem_addr[AW+1:2];
   assign mem_rdata  = mem_q[word_idx];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{mem_addr[XLEN-1:AW+2], mem_addr[1:0]};

   assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
   assign alu_a   = ctrl.alu_src_a ? a_q : fetch_addr;

   always_comb begin
      unique case (ctrl.alu_src_b)
         SRCB_REG:  alu_b = b_q;
         SRCB_FOUR: alu_b = XLEN'(4);
         SRCB_IMM:  alu_b = imm_ext;
         default:   alu_b = {imm_ext[XLEN-3:0], 2'b00};
      endcase
   end

   mcpu_pf_alu u_alu (
      .alu_op (ctrl.alu_op),
      .funct  (ir_q[5:0]),
      .opa    (alu_a),
      .opb    (alu_b),
      .res    (alu_res),
      .zero   (alu_zero)
   );

   always_comb begin
      unique case (ctrl.pc_src)
         PCS_AOUT: pc_next = aout_q;
         PCS_JMP:  pc_next = jump_tgt;
         default:  pc_next = alu_res;
      endcase
   end

   assign pc_en   = ctrl.pc_write | (ctrl.pc_write_cond & alu_zero);
   assign wr_idx  = ctrl.reg_dst ? ir_q[15:11] : ir_q[20:16];
   assign wr_data = ctrl.mem_to_reg ? mdr_q : aout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         ir_q   <= '0;
         mdr_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         aout_q <= '0;
      end else begin
         if (pc_en)         pc_q <= pc_next;
         if (ctrl.ir_write) ir_q <= mem_rdata;
         mdr_q  <= mem_rdata;
         a_q    <= rf_q[ir_q[25:21]];
         b_q    <= rf_q[ir_q[20:16]];
         aout_q <= alu_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) rf_q[i] <= '0;
      end else if (ctrl.reg_write && (wr_idx != '0)) begin
         rf_q[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (load_we)             mem_q[load_addr] <= load_data;
      else if (ctrl.mem_write) mem_q[word_idx]  <= b_q;
   end

   assign dbg_reg_val = rf_q[dbg_reg_sel];
   assign dbg_mem_val = mem_q[dbg_mem_sel];
   assign pc_o        = pc_q;
   assign ir_o        = ir_q;

endmodule

// File: rtl/mcpu_pf_core.sv
module mcpu_pf_core
   import mcpu_pf_pkg::*;
#(
   parameter  int MEM_WORDS   = 64,
   parameter  bit PREFETCH_EN = 1'b1,
   localparam int MEM_AW      = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic [MEM_AW-1:0] load_addr,
   input  logic [31:0]       load_data,
   input  logic [4:0]        dbg_reg_sel,
   output logic [31:0]       dbg_reg_val,
   input  logic [MEM_AW-1:0] dbg_mem_sel,
   output logic [31:0]       dbg_mem_val,
   output logic [31:0]       pc_out,
   output logic [3:0]        state_out,
   output logic              mem_read,
   output logic              mem_write,
   output logic              ir_write,
   output logic              pc_write,
   output logic              pc_write_cond,
   output logic [1:0]        pc_source,
   output logic              alu_src_a,
   output logic [1:0]        alu_src_b,
   output logic [1:0]        alu_op,
   output logic              reg_write,
   output logic              mem_to_reg,
   output logic              reg_dst,
   output logic              i_or_d,
   output logic              pf_jump_sel
);

   generate
      if (MEM_WORDS < 32 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
         $error("MEM_WORDS must be a power of two of at least 32");
      end
      if (XLEN != 32) begin : g_bad_xlen
         $error("datapath width must be 32");
      end
   endgenerate

   state_e st;
   ctrl_t  ctl;
   logic [31:0] ir_w;

   mcpu_pf_ctrl #(.PREFETCH_EN(PREFETCH_EN)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (ir_w[31:26]),
      .state_o (st),
      .ctrl_o  (ctl)
   );

   mcpu_pf_dpath #(.MEM_WORDS(MEM_WORDS)) u_dpath (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl        (ctl),
      .load_we     (load_we),
      .load_addr   (load_addr),
      .load_data   (load_data),
      .dbg_reg_sel (dbg_reg_sel),
      .dbg_reg_val (dbg_reg_val),
      .dbg_mem_sel (dbg_mem_sel),
      .dbg_mem_val (dbg_mem_val),
      .pc_o        (pc_out),
      .ir_o        (ir_w)
   );

   assign state_out     = st;
   assign mem_read      = ctl.mem_read;
   assign mem_write     = ctl.mem_write;
   assign ir_write      = ctl.ir_write;
   assign pc_write      = ctl.pc_write;
   assign pc_write_cond = ctl.pc_write_cond;
   assign pc_source     = ctl.pc_src;
   assign alu_src_a     = ctl.alu_src_a;
   assign alu_src_b     = ctl.alu_src_b;
   assign alu_op        = ctl.alu_op;
   assign reg_write     = ctl.reg_write;
   assign mem_to_reg    = ctl.mem_to_reg;
   assign reg_dst       = ctl.reg_dst;
   assign i_or_d        = ctl.i_or_d;
   assign pf_jump_sel   = ctl.pf_jump_sel;

endmodule

// File: rtl/mcpu_pf_chk.sv
module mcpu_pf_chk #(
   parameter bit PREFETCH_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  state,
   input logic        mem_read,
   input logic        mem_write,
   input logic        ir_write,
   input logic        pc_write,
   input logic        i_or_d,
   input logic        reg_write,
   input logic        mem_to_reg,
   input logic        reg_dst,
   input logic        pf_sel,
   input logic [31:0] pc,
   input logic [31:0] ir
);

   logic tail_state;
   logic known_op;
   assign tail_state = (state == 4'd4) || (state == 4'd7) || (state == 4'd9);
   assign known_op   = (ir[31:26] == 6'b000000) || (ir[31:26] == 6'b100011) ||
                       (ir[31:26] == 6'b101011) || (ir[31:26] == 6'b000100) ||
                       (ir[31:26] == 6'b000010);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (state == 4'd0 && !ir_write && !pc_write &&
                                        !reg_write && !mem_write && !pf_sel && pc == 32'd0)
            else $error("reset state not quiet");
      end
   end

   assert_fetch_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == 4'd0 |-> mem_read && ir_write && pc_write && !i_or_d && !pf_sel);

   assert_ir_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ir_write |=> state == 4'd1);

   assert_mem_rw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_read, mem_write}));

   assert_load_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == 4'd4 |-> reg_write && mem_to_reg && !reg_dst && (ir_write == PREFETCH_EN));

   assert_rtype_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state == 4'd7 |-> reg_write && !mem_to_reg && reg_dst && (ir_write == PREFETCH_EN));

   assert_tail_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      PREFETCH_EN && tail_state |=> state == 4'd1);

   assert_jsel_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pf_sel |-> state == 4'd9 && PREFETCH_EN);

   assert_jump_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pf_sel |=> pc == ({$past(pc[31:28]), $past(ir[25:0]), 2'b00} + 32'd4));

   assert_sw_beq_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'd5 || state == 4'd8) |=> state == 4'd0);

   assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state == 4'd1 && !known_op |=> state == 4'd0 && !reg_write && !mem_write);

   assert_classic_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !PREFETCH_EN && tail_state |=> state == 4'd0);

endmodule

bind mcpu_pf_core mcpu_pf_chk #(.PREFETCH_EN(PREFETCH_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state      (state_out),
   .mem_read   (mem_read),
   .mem_write  (mem_write),
   .ir_write   (ir_write),
   .pc_write   (pc_write),
   .i_or_d     (i_or_d),
   .reg_write  (reg_write),
   .mem_to_reg (mem_to_reg),
   .reg_dst    (reg_dst),
   .pf_sel     (pf_jump_sel),
   .pc         (pc_out),
   .ir         (ir_w)
);

// File: tb/mcpu_pf_core_tb.sv
module mcpu_pf_core_tb_top;

   localparam int MW = 64;
   localparam int AW = $clog2(MW);
   localparam int NREC = 32;
   localparam int NSEQ = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_we = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [31:0] load_data = '0;
   logic [4:0] reg_sel = '0;
   logic [AW-1:0] mem_sel = '0;

   always #5 clk = ~clk;

   logic [31:0] p_reg, p_mem, p_pc, c_reg, c_mem, c_pc;
   logic [3:0]  p_st, c_st;
   logic p_mr, p_mw, p_irw, p_pcw, p_pcc, p_asa, p_rw, p_m2r, p_rd, p_iod, p_pf;
   logic c_mr, c_mw, c_irw, c_pcw, c_pcc, c_asa, c_rw, c_m2r, c_rd, c_iod, c_pf;
   logic [1:0] p_pcs, p_asb, p_aop, c_pcs, c_asb, c_aop;

   mcpu_pf_core #(.MEM_WORDS(MW), .PREFETCH_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .dbg_reg_sel(reg_sel), .dbg_reg_val(p_reg),
      .dbg_mem_sel(mem_sel), .dbg_mem_val(p_mem), .pc_out(p_pc), .state_out(p_st),
      .mem_read(p_mr), .mem_write(p_mw), .ir_write(p_irw), .pc_write(p_pcw),
      .pc_write_cond(p_pcc), .pc_source(p_pcs), .alu_src_a(p_asa), .alu_src_b(p_asb),
      .alu_op(p_aop), .reg_write(p_rw), .mem_to_reg(p_m2r), .reg_dst(p_rd),
      .i_or_d(p_iod), .pf_jump_sel(p_pf));

   mcpu_pf_core #(.MEM_WORDS(MW), .PREFETCH_EN(1'b0)) classic_i (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .dbg_reg_sel(reg_sel), .dbg_reg_val(c_reg),
      .dbg_mem_sel(mem_sel), .dbg_mem_val(c_mem), .pc_out(c_pc), .state_out(c_st),
      .mem_read(c_mr), .mem_write(c_mw), .ir_write(c_irw), .pc_write(c_pcw),
      .pc_write_cond(c_pcc), .pc_source(c_pcs), .alu_src_a(c_asa), .alu_src_b(c_asb),
      .alu_op(c_aop), .reg_write(c_rw), .mem_to_reg(c_m2r), .reg_dst(c_rd),
      .i_or_d(c_iod), .pf_jump_sel(c_pf));

   int n_checks = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Instruction encoders
   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] enc_j(int tgt);
      return {6'b000010, 26'(tgt)};
   endfunction

   // Kinds: 0 load, 1 rtype, 2 jump, 3 store, 4 branch, 5 unknown, 6 data
   function automatic int kind_of(int w);
      case (w)
         0, 1:                return 0;
         2, 3, 4, 5, 6, 8, 9,
         13, 14, 16:          return 1;
         7, 17:               return 2;
         10:                  return 3;
         11, 12:              return 4;
         15:                  return 5;
         default:             return 6;
      endcase
   endfunction

   function automatic logic [31:0] prog_word(int w);
      case (w)
         0:  return enc_i(6'b100011, 0, 1, 160);
         1:  return enc_i(6'b100011, 0, 2, 164);
         2:  return enc_r(1, 2, 3, 6'b100000);
         3:  return enc_r(1, 2, 4, 6'b100010);
         4:  return enc_r(1, 2, 5, 6'b100100);
         5:  return enc_r(1, 2, 6, 6'b100101);
         6:  return enc_r(2, 1, 7, 6'b101010);
         7:  return enc_j(10);
         8:  return enc_r(1, 1, 8, 6'b100000);
         9:  return enc_r(1, 1, 8, 6'b100000);
         10: return enc_i(6'b101011, 0, 3, 168);
         11: return enc_i(6'b000100, 1, 2, 5);
         12: return enc_i(6'b000100, 1, 1, 2);
         13: return enc_r(1, 1, 9, 6'b100000);
         14: return enc_r(1, 1, 9, 6'b100000);
         15: return {6'b111111, 5'd1, 5'd11, 16'd0};
         16: return enc_r(3, 1, 10, 6'b100010);
         17: return enc_j(17);
         40: return 32'd7;
         41: return 32'd5;
         default: return 32'd0;
      endcase
   endfunction

   function automatic int exp_len(int k, bit pf);
      case (k)
         0: return pf ? 4 : 5;
         1: return pf ? 3 : 4;
         2: return pf ? 2 : 3;
         3: return 4;
         4: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic string req_of(int k);
      case (k)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R6";
         default: return "R8";
      endcase
   endfunction

   // Decode-entry recorders
   int cyc = 0;
   int p_t [NREC];
   int p_a [NREC];
   int c_t [NREC];
   int c_a [NREC];
   int p_n = 0;
   int c_n = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc <= cyc + 1;
         if (p_st == 4'd1 && p_n < NREC) begin
            p_t[p_n] <= cyc;
            p_a[p_n] <= int'(p_pc) - 4;
            p_n <= p_n + 1;
         end
         if (c_st == 4'd1 && c_n < NREC) begin
            c_t[c_n] <= cyc;
            c_a[c_n] <= int'(c_pc) - 4;
            c_n <= c_n + 1;
         end
      end
   end

   int exp_seq [NSEQ] = '{0, 4, 8, 12, 16, 20, 24, 28, 40, 44, 48, 60, 64, 68, 68};

   task automatic check_reg(input int r, input longint exp, input string req);
      reg_sel = 5'(r);
      #1;
      check(p_reg == 32'(exp), req, $sformatf("prefetch reg %0d", r), p_reg, exp);
      check(c_reg == 32'(exp), "R9", $sformatf("classic reg %0d", r), c_reg, exp);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R1: quiet reset
      check(p_st == 4'd0, "R1", "reset state", p_st, 0);
      check({p_irw, p_pcw, p_rw, p_mw} == 4'b0, "R1", "reset write enables",
            {p_irw, p_pcw, p_rw, p_mw}, 0);
      check(p_pf == 1'b0, "R1", "reset jump select", p_pf, 0);
      check(p_pc == 32'd0, "R1", "reset pc", p_pc, 0);

      for (int w = 0; w < MW; w++) begin
         load_we   = 1'b1;
         load_addr = AW'(w);
         load_data = prog_word(w);
         @(negedge clk);
      end
      load_we = 1'b0;
      check(p_st == 4'd0 && !p_irw, "R1", "reset held through preload", p_st, 0);

      rst_n = 1'b1;
      #1;
      // R2: fetch controls in state 0
      check(p_mr && p_irw && p_pcw && !p_iod && !p_pf, "R2", "fetch controls",
            {p_mr, p_irw, p_pcw, p_iod, p_pf}, 5'b11100);

      begin : run_wait
         int wd = 0;
         while ((p_n < NSEQ + 1 || c_n < NSEQ + 1) && wd < 3000) begin
            @(negedge clk);
            wd++;
         end
         if (wd >= 3000) check(1'b0, "R7", "watchdog expired", wd, 0);
      end
      #2;

      // Executed address sequence and per-instruction lengths, both builds
      for (int k = 0; k < NSEQ; k++) begin
         string rq;
         rq = (k == 0) ? "R2" : req_of(kind_of(exp_seq[k-1] / 4));
         check(p_a[k] == exp_seq[k], rq, $sformatf("prefetch addr #%0d", k), p_a[k], exp_seq[k]);
         check(c_a[k] == exp_seq[k], "R9", $sformatf("classic addr #%0d", k), c_a[k], exp_seq[k]);
      end
      for (int k = 0; k + 1 < NSEQ; k++) begin
         int kd;
         kd = kind_of(exp_seq[k] / 4);
         check(p_t[k+1] - p_t[k] == exp_len(kd, 1'b1), "R7",
               $sformatf("prefetch clocks at addr %0d", exp_seq[k]),
               p_t[k+1] - p_t[k], exp_len(kd, 1'b1));
         check(c_t[k+1] - c_t[k] == exp_len(kd, 1'b0), "R9",
               $sformatf("classic clocks at addr %0d", exp_seq[k]),
               c_t[k+1] - c_t[k], exp_len(kd, 1'b0));
      end

      // Architectural results
      check_reg(1, 7, "R3");
      check_reg(2, 5, "R3");
      check_reg(3, 7 + 5, "R4");
      check_reg(4, 7 - 5, "R4");
      check_reg(5, 7 & 5, "R4");
      check_reg(6, 7 | 5, "R4");
      check_reg(7, (5 < 7) ? 1 : 0, "R4");
      check_reg(8, 0, "R5");
      check_reg(9, 0, "R6");
      check_reg(10, 12 - 7, "R4");
      check_reg(11, 0, "R8");

      mem_sel = AW'(42);
      #1;
      check(p_mem == 32'd12, "R6", "stored word", p_mem, 12);
      check(c_mem == 32'd12, "R9", "classic stored word", c_mem, 12);
      mem_sel = AW'(43);
      #1;
      check(p_mem == 32'd0, "R8", "untouched word", p_mem, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule